// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This peripheral is a watchdog timer behind a simple single-cycle register bus. A 32-bit counter counts upward on pulses of a slow tick input. An optional power-of-two prescaler can divide that tick. Software programs a reload value, then starts the counter by writing an ordered pair of key words. It keeps the system alive by writing a new pattern to a trigger register. If the counter wraps past its all-ones value while running, the block raises a one-cycle reset request and restarts from the reload value.

Every writable register is posted. A bus write is held in a staging slot for a fixed number of clock cycles before it takes effect, which stands in for a slow-clock crossing. While a write is in flight, its own bit in a status word reads as one. The start/stop key register feeds a small state machine with three states:

- `KS_IDLE` waits for a first key. An arm-first key moves it to `KS_ARM_HALF`. A disarm-first key moves it to `KS_DIS_HALF`. Any other value leaves it in `KS_IDLE`.
- `KS_ARM_HALF` always returns to `KS_IDLE` on the next committed key write. When that value is the arm-second key, the run flag is set on the same transition.
- `KS_DIS_HALF` always returns to `KS_IDLE` on the next committed key write. When that value is the disarm-second key, the run flag is cleared.

Top module: `wdt_top`

## Requirements
- R1: After reset, every readable register reads zero, the counter is stopped, no write is pending, and `wdt_reset_req` is low.
- R2: A bus write to a writable register sets that register's pending bit on the next clock edge. The pending bits sit in the status word at bit 0 (control), bit 2 (load), bit 3 (trigger) and bit 4 (key). The bit stays set for 4 cycles. On the 4th clock edge after the write edge, the bit clears and the written value takes effect.
- R3: The counter starts running only when the committed key writes are 0x0000BBBB followed directly by 0x00004444.
- R4: The counter stops only when the committed key writes are 0x0000AAAA followed directly by 0x00005555. A stopped counter holds its value.
- R5: A committed key write that is not the expected next key returns the sequence to idle. A first key without its matching second key leaves the run state unchanged.
- R6: A committed trigger write reloads the counter from the load register only when its value differs from the last committed trigger value. That last value starts at zero and reads back at the trigger address.
- R7: While running with the prescaler disabled, each tick pulse advances the counter by one. Clock cycles without a tick leave it unchanged.
- R8: The control register has a prescaler enable at bit 5 and a prescale exponent p at bits 4:2. With the enable set, the counter advances once per 2^p tick pulses. The tick divider restarts whenever a control write commits.
- R9: When a running counter advances from 0xFFFFFFFF, it loads the reload value and `wdt_reset_req` is high for exactly the next cycle.
- R10: The read map is:
  - address 0: control. Only bits 5:2 are stored; other bits read zero.
  - address 1: counter.
  - address 2: load.
  - address 3: last trigger value.
  - address 4: run flag, at bit 0.
  - address 5: pending status.
  - addresses 6 and 7: read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse of the slow time base |
| bus_wr | input | 1 | Write strobe, sampled on each rising edge |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| wdt_reset_req | output | 1 | One-cycle reset request on counter wrap |

## Verification
The read port is combinational, so a pending bit is visible right after the write edge. A write's effect is visible right after the fourth edge that follows it. The bench samples both at the falling edge after the relevant rising edge: once with three edges still to go, and once after the fourth. The counter and the reset request change on the edge that samples a tick pulse. The bench pulses the tick for exactly one cycle and checks both outputs at the following falling edge. It checks the reset request again one cycle later, which confirms the pulse has ended.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;
    localparam int SLOT_N = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd2;
    localparam logic [ADDR_W-1:0] A_TRIG  = 3'd3;
    localparam logic [ADDR_W-1:0] A_KEY   = 3'd4;
    localparam logic [ADDR_W-1:0] A_PEND  = 3'd5;

    localparam int SL_CTRL = 0;
    localparam int SL_LOAD = 1;
    localparam int SL_TRIG = 2;
    localparam int SL_KEY  = 3;

    localparam int PRE_EN_BIT  = 5;
    localparam int PRE_VAL_LSB = 2;

    localparam logic [BUS_W-1:0] KEY_ARM_A = 32'h0000_BBBB;
    localparam logic [BUS_W-1:0] KEY_ARM_B = 32'h0000_4444;
    localparam logic [BUS_W-1:0] KEY_DIS_A = 32'h0000_AAAA;
    localparam logic [BUS_W-1:0] KEY_DIS_B = 32'h0000_5555;

    typedef enum logic [1:0] {
        KS_IDLE     = 2'd0,
        KS_ARM_HALF = 2'd1,
        KS_DIS_HALF = 2'd2
    } key_state_e;

    function automatic logic [ADDR_W-1:0] slot_addr(input int s);
        case (s)
            SL_CTRL: slot_addr = A_CTRL;
            SL_LOAD: slot_addr = A_LOAD;
            SL_TRIG: slot_addr = A_TRIG;
            default: slot_addr = A_KEY;
        endcase
    endfunction

    function automatic int pend_pos(input int s);
        case (s)
            SL_CTRL: pend_pos = 0;
            SL_LOAD: pend_pos = 2;
            SL_TRIG: pend_pos = 3;
            default: pend_pos = 4;
        endcase
    endfunction

endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
    parameter int LAT = 4,
    parameter int DW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          pending,
    output logic          commit,
    output logic [DW-1:0] data
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] left_q;
    logic [DW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            hold_q <= '0;
        end else if (wr_en) begin
            left_q <= CW'(LAT);
            hold_q <= wr_data;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pending = (left_q != '0);
    assign commit  = (left_q == CW'(1)) && !wr_en;
    assign data    = hold_q;
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [BUS_W-1:0] key_val,
    output logic             run
);
    key_state_e st_q, st_d;
    logic arm_evt, dis_evt;
    logic run_q;

    always_comb begin
        st_d    = st_q;
        arm_evt = 1'b0;
        dis_evt = 1'b0;
        if (commit) begin
            unique case (st_q)
                KS_IDLE: begin
                    if (key_val == KEY_ARM_A)      st_d = KS_ARM_HALF;
                    else if (key_val == KEY_DIS_A) st_d = KS_DIS_HALF;
                    else                           st_d = KS_IDLE;
                end
                KS_ARM_HALF: begin
                    st_d    = KS_IDLE;
                    arm_evt = (key_val == KEY_ARM_B);
                end
                KS_DIS_HALF: begin
                    st_d    = KS_IDLE;
                    dis_evt = (key_val == KEY_DIS_B);
                end
                default: st_d = KS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= KS_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 1'b0;
        else if (arm_evt) run_q <= 1'b1;
        else if (dis_evt) run_q <= 1'b0;
    end

    assign run = run_q;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pre_en,
    input  logic [PW-1:0] pre_val,
    input  logic          restart,
    output logic          adv
);
    localparam int DIVW = (1 << PW) - 1;

    logic [DIVW-1:0] div_q;
    logic [DIVW-1:0] lim;
    logic            at_lim;

    assign lim    = ~({DIVW{1'b1}} << pre_val);
    assign at_lim = (div_q == lim);
    assign adv    = tick && (!pre_en || at_lim);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q <= '0;
        end else if (tick && pre_en) begin
            div_q <= at_lim ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int LAT = 4,
    parameter int CW  = 32,
    parameter int PW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              wdt_reset_req
);
    logic [SLOT_N-1:0] pend_vec;
    logic [SLOT_N-1:0] slot_commit;
    logic [BUS_W-1:0]  slot_data [SLOT_N];

    genvar s;
    generate
        for (s = 0; s < SLOT_N; s++) begin : g_slot
            wdt_post_slot #(.LAT(LAT), .DW(BUS_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (bus_wr && (bus_addr == slot_addr(s))),
                .wr_data (bus_wdata),
                .pending (pend_vec[s]),
                .commit  (slot_commit[s]),
                .data    (slot_data[s])
            );
        end
    endgenerate

    logic          pre_en_q;
    logic [PW-1:0] pre_val_q;
    logic [CW-1:0] load_q;
    logic [CW-1:0] trig_last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_en_q    <= 1'b0;
            pre_val_q   <= '0;
            load_q      <= '0;
            trig_last_q <= '0;
        end else begin
            if (slot_commit[SL_CTRL]) begin
                pre_en_q  <= slot_data[SL_CTRL][PRE_EN_BIT];
                pre_val_q <= slot_data[SL_CTRL][PRE_VAL_LSB +: PW];
            end
            if (slot_commit[SL_LOAD]) load_q      <= slot_data[SL_LOAD][CW-1:0];
            if (slot_commit[SL_TRIG]) trig_last_q <= slot_data[SL_TRIG][CW-1:0];
        end
    end

    logic run_q;

    wdt_key_fsm u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (slot_commit[SL_KEY]),
        .key_val (slot_data[SL_KEY]),
        .run     (run_q)
    );

    logic adv;

    wdt_prescaler #(.PW(PW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_i),
        .pre_en  (pre_en_q),
        .pre_val (pre_val_q),
        .restart (slot_commit[SL_CTRL]),
        .adv     (adv)
    );

    logic [CW-1:0] count_q;
    logic          rst_req_q;
    logic          trig_reload;

    assign trig_reload = slot_commit[SL_TRIG] &&
                         (slot_data[SL_TRIG][CW-1:0] != trig_last_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= 1'b0;
            if (trig_reload) begin
                count_q <= load_q;
            end else if (run_q && adv) begin
                if (&count_q) begin
                    count_q   <= load_q;
                    rst_req_q <= 1'b1;
                end else begin
                    count_q <= count_q + 1'b1;
                end
            end
        end
    end

    assign wdt_reset_req = rst_req_q;

    logic [BUS_W-1:0] pend_word;
    logic [BUS_W-1:0] ctrl_word;

    always_comb begin
        pend_word = '0;
        for (int k = 0; k < SLOT_N; k++) pend_word[pend_pos(k)] = pend_vec[k];
        ctrl_word = '0;
        ctrl_word[PRE_EN_BIT] = pre_en_q;
        ctrl_word[PRE_VAL_LSB +: PW] = pre_val_q;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_word;
            A_COUNT: bus_rdata = BUS_W'(count_q);
            A_LOAD:  bus_rdata = BUS_W'(load_q);
            A_TRIG:  bus_rdata = BUS_W'(trig_last_q);
            A_KEY:   bus_rdata = BUS_W'(run_q);
            A_PEND:  bus_rdata = pend_word;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int CW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wdt_reset_req,
    input logic [SLOT_N-1:0] pend_vec,
    input logic [SLOT_N-1:0] slot_commit,
    input logic              run_q,
    input logic [CW-1:0]     count_q
);
    AST_LOAD_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LOAD) |=> pend_vec[SL_LOAD]); // R2

    AST_RUN_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> $past(slot_commit[SL_KEY])); // R3

    AST_STOP_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past(slot_commit[SL_KEY])); // R4

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !slot_commit[SL_TRIG]) |=> $stable(count_q)); // R7

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_req |=> !wdt_reset_req); // R9

    AST_RST_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_req |-> $past(run_q)); // R9
endmodule

bind wdt_top wdt_chk #(.CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .wdt_reset_req (wdt_reset_req),
    .pend_vec      (pend_vec),
    .slot_commit   (slot_commit),
    .run_q         (run_q),
    .count_q       (count_q)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        wdt_reset_req;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wdt_top dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick_i),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .wdt_reset_req (wdt_reset_req)
    );

    // {address, write data, expected readback after commit}
    localparam logic [66:0] VEC [0:7] = '{
        {3'd0, 32'h0000_003C, 32'h0000_003C},
        {3'd0, 32'hFFFF_FFFF, 32'h0000_003C},
        {3'd0, 32'h0000_0020, 32'h0000_0020},
        {3'd0, 32'h0000_0000, 32'h0000_0000},
        {3'd2, 32'h1234_5678, 32'h1234_5678},
        {3'd2, 32'hFFFF_FFF0, 32'hFFFF_FFF0},
        {3'd3, 32'h0000_0005, 32'h0000_0005},
        {3'd3, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_req(input logic exp, input string tag);
        n_chk++;
        if (wdt_reset_req !== exp) begin
            n_bad++;
            $display("FAIL %s reset_req actual=%b expected=%b", tag, wdt_reset_req, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic wr_commit(input logic [2:0] a, input logic [31:0] d);
        wr(a, d);
        wait_n(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_rd(3'd0, 32'h0, "R1 ctrl");
        chk_rd(3'd1, 32'h0, "R1 count");
        chk_rd(3'd2, 32'h0, "R1 load");
        chk_rd(3'd3, 32'h0, "R1 trig");
        chk_rd(3'd4, 32'h0, "R1 run");
        chk_rd(3'd5, 32'h0, "R1 pend");
        chk_req(1'b0, "R1");

        // R10 register readback table
        for (int i = 0; i < 8; i++) begin
            wr_commit(VEC[i][66:64], VEC[i][63:32]);
            chk_rd(VEC[i][66:64], VEC[i][31:0], "R10 table");
        end
        chk_rd(3'd6, 32'h0, "R10 unmapped");
        // R6: both trigger writes in the table differed, so the counter holds the load value
        chk_rd(3'd1, 32'hFFFF_FFF0, "R6 reload");

        // R2 pending window, load and control
        wr(3'd2, 32'hFFFF_FFF0);
        chk_rd(3'd5, 32'h4, "R2 load pend set");
        wait_n(3);
        chk_rd(3'd5, 32'h4, "R2 load pend held");
        wait_n(1);
        chk_rd(3'd5, 32'h0, "R2 load pend clear");
        wr(3'd0, 32'h0);
        chk_rd(3'd5, 32'h1, "R2 ctrl pend");
        wait_n(4);
        chk_rd(3'd5, 32'h0, "R2 ctrl clear");

        // R7 stopped counter holds
        ticks(3);
        chk_rd(3'd1, 32'hFFFF_FFF0, "R7 stopped hold");

        // R5 broken arm sequence
        wr_commit(3'd4, 32'h0000_BBBB);
        wr_commit(3'd4, 32'h0000_1234);
        wr_commit(3'd4, 32'h0000_4444);
        chk_rd(3'd4, 32'h0, "R5 broken arm");

        // R3 arm, with key pending bit (R2) and lone first key (R5)
        wr(3'd4, 32'h0000_BBBB);
        chk_rd(3'd5, 32'h10, "R2 key pend");
        wait_n(4);
        chk_rd(3'd4, 32'h0, "R5 first key only");
        wr_commit(3'd4, 32'h0000_4444);
        chk_rd(3'd4, 32'h1, "R3 armed");

        // R7 counting without prescaler
        ticks(5);
        chk_rd(3'd1, 32'hFFFF_FFF5, "R7 count");
        wait_n(3);
        chk_rd(3'd1, 32'hFFFF_FFF5, "R7 no tick");

        // R6 trigger pattern rule
        wr_commit(3'd3, 32'h0000_0000);
        chk_rd(3'd1, 32'hFFFF_FFF5, "R6 same pattern");
        wr_commit(3'd3, 32'h0000_EDCB);
        chk_rd(3'd1, 32'hFFFF_FFF0, "R6 new pattern");

        // R9 wrap
        ticks(15);
        chk_rd(3'd1, 32'hFFFF_FFFF, "R9 at top");
        chk_req(1'b0, "R9 before wrap");
        ticks(1);
        chk_req(1'b1, "R9 pulse");
        chk_rd(3'd1, 32'hFFFF_FFF0, "R9 reload");
        wait_n(1);
        chk_req(1'b0, "R9 pulse end");

        // R5 lone disarm key while running
        wr_commit(3'd4, 32'h0000_AAAA);
        wr_commit(3'd4, 32'h0000_1111);
        chk_rd(3'd4, 32'h1, "R5 lone disarm");
        ticks(1);
        chk_rd(3'd1, 32'hFFFF_FFF1, "R5 still counting");

        // R8 prescaler
        wr_commit(3'd0, 32'h0000_0028);
        ticks(3);
        chk_rd(3'd1, 32'hFFFF_FFF1, "R8 div4 hold");
        ticks(1);
        chk_rd(3'd1, 32'hFFFF_FFF2, "R8 div4 step");
        wr_commit(3'd0, 32'h0000_0024);
        ticks(1);
        chk_rd(3'd1, 32'hFFFF_FFF2, "R8 div2 hold");
        ticks(1);
        chk_rd(3'd1, 32'hFFFF_FFF3, "R8 div2 step");
        wr_commit(3'd0, 32'h0000_0008);
        ticks(1);
        chk_rd(3'd1, 32'hFFFF_FFF4, "R8 disabled");

        // R4 disarm
        wr_commit(3'd4, 32'h0000_AAAA);
        wr_commit(3'd4, 32'h0000_5555);
        chk_rd(3'd4, 32'h0, "R4 stopped");
        ticks(2);
        chk_rd(3'd1, 32'hFFFF_FFF4, "R4 hold");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule